// File: doc/BRIEF.md
# Transmit Word-to-Byte Alignment Unpacker

This block sits between a word-wide transmit buffer, filled by aligned DMA reads, and a byte-wide MAC transmit FIFO. It breaks each incoming word into bytes and passes them out one per handshake. A frame can start at any byte offset in memory. The DMA engine still fetches whole aligned words. With the first word of every frame the descriptor supplies a skip count of 0 to 3, and the block drops that many leading bytes before it emits anything.

The frame byte length arrives with the first word, together with the skip count. Both are held until the frame ends. Output stops after exactly that many bytes and the final byte is flagged as end-of-frame. Bytes left over in the last word are dropped. Any further words of the frame are taken in and dropped. A per-frame select picks the order in which bytes are taken from a word: most-significant lane first, or least-significant lane first.

The controller is a four-state machine:
- **ST_IDLE** waits for a word that carries the first flag.
- **ST_EMIT** presents the bytes of the held word.
- **ST_FETCH** waits for the next word of the same frame.
- **ST_FLUSH** drops words until the last flag.

The transitions are:
- **IDLE→EMIT**: a first word with a non-zero length is accepted.
- **IDLE→FLUSH**: a first word with zero length is accepted, and it is not last.
- **IDLE→IDLE**: a word without the first flag, or a zero-length single-word frame, is accepted.
- **EMIT→FETCH**: the top lane is taken and the frame is not finished.
- **EMIT→IDLE**: the final byte is taken and the held word was last.
- **EMIT→FLUSH**: the final byte is taken and more words remain.
- **FETCH→EMIT**: the next word is accepted.
- **FLUSH→IDLE**: a word with the last flag is accepted.

Top module: `tx_align_unpacker`

## Requirements
- R1: After reset, out_valid and out_eof are 0 and in_ready is 1.
- R2: When a first word is accepted with skip count s (0..3), the first s byte lanes of that word are never emitted. The first emitted byte is lane s.
- R3: With little_endian=0, lane 0 is in_data[31:24] and lane 3 is in_data[7:0].
- R4: With little_endian=1, lane 0 is in_data[7:0] and lane 3 is in_data[31:24].
- R5: A frame emits exactly frame-length bytes, provided the words hold that many after the skip. The remaining lanes of that word are dropped, and further words up to the last flag are accepted without output.
- R6: out_eof is 1 on the final emitted byte of a frame and 0 on every other byte. After the final byte is taken, out_valid is 0 in the next cycle.
- R7: in_ready and out_valid are never 1 together. A new word is taken only after all lanes of the held word are emitted or dropped.
- R8: Skip count and frame length are sampled only with the first word. Values on in_skip and in_len during later words have no effect.
- R9: A word offered in ST_IDLE without in_first is accepted and dropped, and no byte is emitted for it.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_eof hold their values.
- R11: A frame of length 0 emits no byte.
- R12: If the frame's last word runs out before frame-length bytes, the last available lane is emitted with out_eof=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken this cycle |
| in_data | input | 32 | Transmit word |
| in_first | input | 1 | Word is the first of a frame |
| in_last | input | 1 | Word is the last of a frame |
| in_skip | input | 2 | Leading bytes to drop, sampled with the first word |
| in_len | input | 16 | Frame length in bytes, sampled with the first word |
| little_endian | input | 1 | Byte extraction order select |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Byte taken when out_valid is also 1 |
| out_data | output | 8 | Transmit byte |
| out_eof | output | 1 | Byte is the final byte of the frame |

## Verification
The hardest situations to reach from the ports are the end-of-frame cases where length and word supply disagree. In one, the length runs out while more words are still coming, so the block must flush them. In the other, the last word arrives before the length is used up. The stimulus table builds frames of one to four words and, in separate entries, gives them lengths that are too short, exact, too long and zero. Some entries also stall the byte side in a repeating pattern, so the end-of-frame byte sometimes waits under back-pressure. Every word after the first carries deliberately wrong skip and length values, so a design that re-samples them produces a wrong byte stream.

// File: rtl/txu_pkg.sv
package txu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FETCH = 2'd2,
        ST_FLUSH = 2'd3
    } txu_state_e;
endpackage

// File: rtl/txu_lane_select.sv
module txu_lane_select #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  lane,
    input  logic              lsb_first,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] msb_order [LANES];
    logic [BYTE_W-1:0] lsb_order [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign msb_order[j] = word[WORD_W-1-j*BYTE_W -: BYTE_W];
        assign lsb_order[j] = word[j*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_out = lsb_first ? lsb_order[lane] : msb_order[lane];
    end
endmodule

// File: rtl/txu_len_counter.sv
module txu_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             rem_one
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign rem_one = (rem_q == LEN_W'(1));
endmodule

// File: rtl/tx_align_unpacker.sv
module tx_align_unpacker #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 16,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [IDX_W-1:0]  in_skip,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              little_endian,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eof
);
    import txu_pkg::*;

    localparam logic [IDX_W-1:0] TOP_LANE = IDX_W'(LANES - 1);

    txu_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              last_q;
    logic [IDX_W-1:0]  lane_q;

    logic in_take, out_take, start_frame, len_zero, rem_one, final_byte;

    assign in_take     = in_valid && in_ready;
    assign out_take    = out_valid && out_ready;
    assign start_frame = (state_q == ST_IDLE) && in_take && in_first;
    assign len_zero    = (in_len == '0);
    assign final_byte  = rem_one || (last_q && lane_q == TOP_LANE);

    txu_len_counter #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_frame),
        .load_val (in_len),
        .dec      (out_take),
        .rem_one  (rem_one)
    );

    txu_lane_select #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_sel (
        .word      (word_q),
        .lane      (lane_q),
        .lsb_first (little_endian),
        .byte_out  (out_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_take && in_first) begin
                    if (!len_zero)     state_d = ST_EMIT;
                    else if (!in_last) state_d = ST_FLUSH;
                end
            end
            ST_EMIT: begin
                if (out_take) begin
                    if (final_byte)                state_d = last_q ? ST_IDLE : ST_FLUSH;
                    else if (lane_q == TOP_LANE)   state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (in_take) state_d = ST_EMIT;
            end
            ST_FLUSH: begin
                if (in_take && in_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Word holding register and lane pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            last_q <= 1'b0;
            lane_q <= '0;
        end else if (start_frame) begin
            word_q <= in_data;
            last_q <= in_last;
            lane_q <= in_skip;
        end else if (state_q == ST_FETCH && in_take) begin
            word_q <= in_data;
            last_q <= in_last;
            lane_q <= '0;
        end else if (out_take) begin
            lane_q <= lane_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_eof   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FETCH, ST_FLUSH: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                out_eof   = final_byte;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txu_checker.sv
module txu_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_eof
);
    // R7
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    // R6
    eof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    // R6
    eof_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);
endmodule

bind tx_align_unpacker txu_checker #(.BYTE_W(BYTE_W)) u_txu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_eof   (out_eof)
);

// File: tb/test_tx_align_unpacker.sv
`timescale 1ns/1ps
module test_tx_align_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        in_first = 1'b0, in_last = 1'b0;
    logic [1:0]  in_skip = '0;
    logic [15:0] in_len = '0;
    logic        little_endian = 1'b0;
    logic        out_valid, out_ready = 1'b0, out_eof;
    logic [7:0]  out_data;

    int checks = 0, errors = 0, cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tx_align_unpacker i_tx_align_unpacker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .in_skip(in_skip), .in_len(in_len), .little_endian(little_endian),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_eof(out_eof)
    );

    typedef struct packed {
        logic [1:0]  skip;
        logic [15:0] len;
        logic        le;
        logic [2:0]  nw;
        logic        stall;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'd8,  1'b0, 3'd2, 1'b0},
        '{2'd1, 16'd7,  1'b0, 3'd2, 1'b1},
        '{2'd2, 16'd6,  1'b1, 3'd2, 1'b0},
        '{2'd3, 16'd5,  1'b1, 3'd2, 1'b1},
        '{2'd3, 16'd1,  1'b0, 3'd1, 1'b0},
        '{2'd1, 16'd5,  1'b0, 3'd3, 1'b1},
        '{2'd0, 16'd0,  1'b0, 3'd2, 1'b0},
        '{2'd2, 16'd20, 1'b1, 3'd3, 1'b1},
        '{2'd0, 16'd13, 1'b1, 3'd4, 1'b0},
        '{2'd2, 16'd9,  1'b0, 3'd4, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int v, input int i);
        return 8'(8'h10 * v + i * 3 + 1);
    endfunction

    // R3 lane 0 at bits 31:24, R4 lane 0 at bits 7:0
    function automatic logic [31:0] pack(input int v, input int k, input bit le);
        logic [7:0] b0, b1, b2, b3;
        b0 = mbyte(v, 4*k); b1 = mbyte(v, 4*k+1);
        b2 = mbyte(v, 4*k+2); b3 = mbyte(v, 4*k+3);
        return le ? {b3, b2, b1, b0} : {b0, b1, b2, b3};
    endfunction

    task automatic send_word(input logic [31:0] d, input bit f, input bit l,
                             input logic [1:0] s, input logic [15:0] n);
        in_data = d; in_first = f; in_last = l; in_skip = s; in_len = n;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input int v, input vec_t t);
        int  avail, expn, got, idle;
        bit  drv_done, prev_stall, rdy;
        logic [7:0] prev_data;
        string rq;
        avail = 4 * int'(t.nw) - int'(t.skip);
        expn  = (int'(t.len) < avail) ? int'(t.len) : avail;
        got = 0; idle = 0; drv_done = 0; prev_stall = 0; prev_data = '0;
        little_endian = t.le;
        fork
            begin
                for (int k = 0; k < int'(t.nw); k++) begin
                    // R8: later words carry wrong skip and length
                    send_word(pack(v, k, t.le), k == 0, k == int'(t.nw) - 1,
                              k == 0 ? t.skip : ~t.skip,
                              k == 0 ? t.len : t.len + 16'd5);
                end
                drv_done = 1;
            end
            begin
                while (!drv_done || idle < 6) begin
                    @(negedge clk);
                    if (prev_stall)
                        chk(out_valid && out_data == prev_data, "R10", out_data, prev_data);
                    if (out_valid) chk(!in_ready, "R7", in_ready, 0);
                    rdy = t.stall ? ((cyc % 3) != 0) : 1'b1;
                    out_ready = rdy;
                    prev_stall = out_valid && !rdy;
                    prev_data  = out_data;
                    if (out_valid && rdy) begin
                        rq = (got == 0 && t.skip != 0) ? "R2" : (t.le ? "R4" : "R3");
                        chk(out_data == mbyte(v, int'(t.skip) + got), rq, out_data,
                            mbyte(v, int'(t.skip) + got));
                        rq = (int'(t.len) > avail) ? "R12" : "R6";
                        chk(out_eof == (got == expn - 1), rq, out_eof, got == expn - 1);
                        got++;
                        idle = 0;
                    end else begin
                        idle++;
                    end
                end
            end
        join
        out_ready = 1'b0;
        rq = (t.len == 0) ? "R11" : ((int'(t.len) > avail) ? "R12" : "R5");
        chk(got == expn, rq, got, expn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid, "R1", out_valid, 0);
        chk(!out_eof, "R1", out_eof, 0);
        chk(in_ready, "R1", in_ready, 1);

        // R9: stray word in idle without the first flag
        send_word(32'hDEAD_BEEF, 1'b0, 1'b0, 2'd1, 16'd4);
        for (int i = 0; i < 3; i++) begin
            chk(!out_valid && in_ready, "R9", out_valid, 0);
            @(negedge clk);
        end

        for (int v = 0; v < NV; v++) run_frame(v, VEC[v]);

        // Back-to-back after a flushed frame, then a stray word again (R9)
        send_word(32'h0102_0304, 1'b0, 1'b1, 2'd0, 16'd2);
        chk(!out_valid, "R9", out_valid, 0);
        run_frame(11, '{2'd0, 16'd4, 1'b0, 3'd1, 1'b0});
        run_frame(12, '{2'd1, 16'd3, 1'b1, 3'd1, 1'b1});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule